// File: doc/BRIEF.md
# Program Exception Cause Detector

This block sits in the completion stage of a processor pipeline. Each time an instruction retires, it looks at the decode flags for that instruction and the user/supervisor mode bit. It also looks at the handler-base select bit and the two floating-point exception mode bits. Last, it takes the floating-point enable and sticky flags and the trap-condition results. From these it decides whether a program-type exception must be taken.

When an exception is taken, the block reports one cause as a single bit of a save/restore status word and gives the handler fetch address. Exceptions of higher priority are resolved elsewhere and reach this block only as one inhibit line.

The block also drives a short completion stall. The stall covers the case where a retiring floating-point instruction sets a sticky flag while that condition is masked and both floating-point exception mode bits are clear. In that case the flag update has to be serialized.

Top module: `prog_exc_detect`

## Requirements
- R1: `exc_req` is 1 in the cycle after a cycle with `retire_vld`=1, `hi_inhibit`=0 and at least one cause present. In every other cycle it is 0.
- R2: When a request is made, `exc_vector` is 0x00000700 if `msr_ip`=0 and 0xFFF00700 if `msr_ip`=1.
- R3: The illegal cause is present when `dec_illegal`=1 and `dec_nop_opt`=0. An instruction flagged as an optional no-op never raises it.
- R4: The privileged cause is present when `dec_supv`=1 and `msr_pr`=1. A supervisor-only instruction retired with `msr_pr`=0 raises nothing.
- R5: A special-register move (`dec_spr_move`=1) with `spr_invalid`=1 raises the privileged cause only when `spr_top`=1 and `msr_pr`=1.
- R6: The trap cause is present when `trap_op`=1 and at least one bit position is 1 in both `trap_sel` and `trap_hit`.
- R7: The floating-point cause is present when (`msr_fe0` OR `msr_fe1`) is 1 and at least one bit position is 1 in both `fp_flags` and `fp_en`.
- R8: Only one cause is reported in `exc_srr1`, chosen in this order: illegal, then privileged, then trap, then floating-point. The bit used is 12 for illegal, 13 for privileged, 14 for trap and 11 for floating-point. `exc_srr1` is zero whenever `exc_req`=0.
- R9: A retire with both FE bits 0 and some bit set in `fp_flags & ~fp_sticky & ~fp_en` raises `comp_stall` starting in the next cycle. The stall lasts 1 cycle when `fp_sum_upd`=0 and 2 cycles when `fp_sum_upd`=1. Any other retire gives no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| hi_inhibit | input | 1 | An exception of higher priority is pending |
| msr_pr | input | 1 | User mode bit |
| msr_ip | input | 1 | Handler base select |
| msr_fe0 | input | 1 | Floating-point exception mode bit 0 |
| msr_fe1 | input | 1 | Floating-point exception mode bit 1 |
| dec_illegal | input | 1 | Opcode or opcode pair is illegal or not implemented |
| dec_nop_opt | input | 1 | Optional instruction that is executed as a no-op |
| dec_supv | input | 1 | Supervisor-only instruction |
| dec_spr_move | input | 1 | Move to or from a special register |
| spr_invalid | input | 1 | Special register number is not implemented |
| spr_top | input | 1 | Top bit of the special register number field |
| trap_op | input | 1 | The instruction is a trap |
| trap_sel | input | NTRAP | Conditions selected by the trap |
| trap_hit | input | NTRAP | Comparison results |
| fp_flags | input | NFP | Exception flags produced by the instruction |
| fp_sticky | input | NFP | Sticky flags already set |
| fp_en | input | NFP | Per-condition enables |
| fp_sum_upd | input | 1 | The instruction also updates the summary flags |
| exc_req | output | 1 | Program exception taken |
| exc_srr1 | output | 32 | Cause word, one bit set on a request |
| exc_vector | output | 32 | Handler fetch address |
| comp_stall | output | 1 | Completion serialization stall |

## Verification
The bench targets the cases where one condition is present but has to be suppressed:
- An optional no-op that also carries the illegal flag must stay silent; a design that ignores the no-op flag would trap on it.
- An invalid special-register move whose top number bit is 0 must stay silent; a design that ignores the top bit would raise a false privileged fault.
- A trap whose selected conditions and hit results do not overlap must stay silent; a design that tests only `trap_hit` would fire anyway.
- An enabled flag with both FE bits clear must stay silent; a design that skips the FE gate would fire anyway.

The bench also steps through every pair of causes along the priority order, which exposes a swapped priority. It checks the stall length with and without a summary update, and it checks that a flag which was already sticky causes no stall.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int NCAUSE  = 4;
  localparam int CI_FP   = 0;
  localparam int CI_ILL  = 1;
  localparam int CI_PRIV = 2;
  localparam int CI_TRAP = 3;
  // Cause index i lands at status bit SRR1_LSB + i.
  localparam int SRR1_LSB = 11;

  // Keeps only the highest-ranked cause: illegal > privileged > trap > fp.
  function automatic logic [NCAUSE-1:0] prio_pick(input logic [NCAUSE-1:0] raw);
    logic [NCAUSE-1:0] s;
    s = '0;
    if (raw[CI_ILL])       s[CI_ILL]  = 1'b1;
    else if (raw[CI_PRIV]) s[CI_PRIV] = 1'b1;
    else if (raw[CI_TRAP]) s[CI_TRAP] = 1'b1;
    else if (raw[CI_FP])   s[CI_FP]   = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/pe_cause_eval.sv
module pe_cause_eval
  import pe_pkg::*;
#(
  parameter int NFP   = 5,
  parameter int NTRAP = 5
) (
  input  logic              msr_pr,
  input  logic              msr_fe0,
  input  logic              msr_fe1,
  input  logic              dec_illegal,
  input  logic              dec_nop_opt,
  input  logic              dec_supv,
  input  logic              dec_spr_move,
  input  logic              spr_invalid,
  input  logic              spr_top,
  input  logic              trap_op,
  input  logic [NTRAP-1:0]  trap_sel,
  input  logic [NTRAP-1:0]  trap_hit,
  input  logic [NFP-1:0]    fp_flags,
  input  logic [NFP-1:0]    fp_en,
  output logic [NCAUSE-1:0] cause_raw,
  output logic [NCAUSE-1:0] cause_sel
);
  logic ill_w, priv_w, spr_priv_w, trap_w, fp_w;

  assign ill_w      = dec_illegal & ~dec_nop_opt;
  assign spr_priv_w = dec_spr_move & spr_invalid & spr_top;
  assign priv_w     = msr_pr & (dec_supv | spr_priv_w);
  assign trap_w     = trap_op & (|(trap_sel & trap_hit));
  assign fp_w       = (msr_fe0 | msr_fe1) & (|(fp_flags & fp_en));

  always_comb begin
    cause_raw          = '0;
    cause_raw[CI_ILL]  = ill_w;
    cause_raw[CI_PRIV] = priv_w;
    cause_raw[CI_TRAP] = trap_w;
    cause_raw[CI_FP]   = fp_w;
  end

  assign cause_sel = prio_pick(cause_raw);
endmodule

// File: rtl/pe_fp_serial.sv
module pe_fp_serial #(
  parameter int NFP   = 5,
  parameter int LEN_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           retire_vld,
  input  logic           fe_any,
  input  logic [NFP-1:0] fp_flags,
  input  logic [NFP-1:0] fp_sticky,
  input  logic [NFP-1:0] fp_en,
  input  logic           sum_upd,
  output logic           comp_stall
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

  logic [NFP-1:0]   new_bits;
  logic             quiet_set;
  logic [LEN_W-1:0] cnt_q;

  assign new_bits  = fp_flags & ~fp_sticky;
  assign quiet_set = ~fe_any & (|(new_bits & ~fp_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (retire_vld)     cnt_q <= quiet_set ? (sum_upd ? LEN_TWO : LEN_ONE) : '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - LEN_ONE;
  end

  assign comp_stall = (cnt_q != '0);

  AST_STALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && fe_any) |=> !comp_stall);  // R9
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_vld && !comp_stall) |=> !comp_stall);  // R9
endmodule

// File: rtl/prog_exc_detect.sv
module prog_exc_detect
  import pe_pkg::*;
#(
  parameter int               NFP     = 5,
  parameter int               NTRAP   = 5,
  parameter int               ADDR_W  = 32,
  parameter int               SRR1_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFF0_0000,
  parameter logic [11:0]      VEC_OFS = 12'h700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_vld,
  input  logic              hi_inhibit,
  input  logic              msr_pr,
  input  logic              msr_ip,
  input  logic              msr_fe0,
  input  logic              msr_fe1,
  input  logic              dec_illegal,
  input  logic              dec_nop_opt,
  input  logic              dec_supv,
  input  logic              dec_spr_move,
  input  logic              spr_invalid,
  input  logic              spr_top,
  input  logic              trap_op,
  input  logic [NTRAP-1:0]  trap_sel,
  input  logic [NTRAP-1:0]  trap_hit,
  input  logic [NFP-1:0]    fp_flags,
  input  logic [NFP-1:0]    fp_sticky,
  input  logic [NFP-1:0]    fp_en,
  input  logic              fp_sum_upd,
  output logic              exc_req,
  output logic [SRR1_W-1:0] exc_srr1,
  output logic [ADDR_W-1:0] exc_vector,
  output logic              comp_stall
);
  localparam logic [ADDR_W-1:0] OFS_EXT = ADDR_W'(VEC_OFS);

  logic [NCAUSE-1:0] cause_raw, cause_sel;
  logic              take_w;
  logic [ADDR_W-1:0] vec_next;
  logic [SRR1_W-1:0] srr1_next;

  pe_cause_eval #(.NFP(NFP), .NTRAP(NTRAP)) u_cause (
    .msr_pr(msr_pr), .msr_fe0(msr_fe0), .msr_fe1(msr_fe1),
    .dec_illegal(dec_illegal), .dec_nop_opt(dec_nop_opt), .dec_supv(dec_supv),
    .dec_spr_move(dec_spr_move), .spr_invalid(spr_invalid), .spr_top(spr_top),
    .trap_op(trap_op), .trap_sel(trap_sel), .trap_hit(trap_hit),
    .fp_flags(fp_flags), .fp_en(fp_en),
    .cause_raw(cause_raw), .cause_sel(cause_sel)
  );

  pe_fp_serial #(.NFP(NFP), .LEN_W(2)) u_serial (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld),
    .fe_any(msr_fe0 | msr_fe1), .fp_flags(fp_flags), .fp_sticky(fp_sticky),
    .fp_en(fp_en), .sum_upd(fp_sum_upd), .comp_stall(comp_stall)
  );

  assign take_w   = retire_vld & ~hi_inhibit & (|cause_raw);
  assign vec_next = (msr_ip ? HI_BASE : '0) | OFS_EXT;

  always_comb begin
    srr1_next = '0;
    for (int i = 0; i < NCAUSE; i++) srr1_next[SRR1_LSB + i] = cause_sel[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req    <= 1'b0;
      exc_srr1   <= '0;
      exc_vector <= '0;
    end else begin
      exc_req  <= take_w;
      exc_srr1 <= take_w ? srr1_next : '0;
      if (take_w) exc_vector <= vec_next;
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> !exc_req);  // R1
  AST_INHIBIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hi_inhibit |=> !exc_req);  // R1
  AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vector[11:0] == VEC_OFS));  // R2
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $onehot(exc_srr1));  // R8
  AST_QUIET_SRR1: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> (exc_srr1 == '0));  // R8
  AST_ILLEGAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && !hi_inhibit && cause_raw[CI_ILL]) |=> exc_srr1[SRR1_LSB + CI_ILL]);  // R8
endmodule

// File: tb/prog_exc_detect_tb_top.sv
module prog_exc_detect_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic inh, pr, ip, fe0, fe1, ill, nop, supv, spr_mv, spr_inv, spr_top, trap, sum;
    logic [4:0] tsel, thit, flags, sticky, en;
  } stim_t;

  typedef struct {
    logic        req;
    logic [31:0] srr1;
    logic [31:0] vec;
    int          stall;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic retire_vld = 0, hi_inhibit = 0, msr_pr = 0, msr_ip = 0, msr_fe0 = 0, msr_fe1 = 0;
  logic dec_illegal = 0, dec_nop_opt = 0, dec_supv = 0, dec_spr_move = 0;
  logic spr_invalid = 0, spr_top = 0, trap_op = 0, fp_sum_upd = 0;
  logic [4:0] trap_sel = 0, trap_hit = 0, fp_flags = 0, fp_sticky = 0, fp_en = 0;
  logic exc_req, comp_stall;
  logic [31:0] exc_srr1, exc_vector;

  int checks = 0, errors = 0, rem = 0;
  bit mon_en = 0, done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_exc_detect dut_i (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .hi_inhibit(hi_inhibit),
    .msr_pr(msr_pr), .msr_ip(msr_ip), .msr_fe0(msr_fe0), .msr_fe1(msr_fe1),
    .dec_illegal(dec_illegal), .dec_nop_opt(dec_nop_opt), .dec_supv(dec_supv),
    .dec_spr_move(dec_spr_move), .spr_invalid(spr_invalid), .spr_top(spr_top),
    .trap_op(trap_op), .trap_sel(trap_sel), .trap_hit(trap_hit),
    .fp_flags(fp_flags), .fp_sticky(fp_sticky), .fp_en(fp_en), .fp_sum_upd(fp_sum_upd),
    .exc_req(exc_req), .exc_srr1(exc_srr1), .exc_vector(exc_vector), .comp_stall(comp_stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic stim_t blank();
    return '0;
  endfunction

  function automatic exp_t predict(input stim_t s, input string tag);
    exp_t e;
    bit c_ill, c_priv, c_trap, c_fp;
    c_ill  = s.ill && !s.nop;
    c_priv = s.pr && (s.supv || (s.spr_mv && s.spr_inv && s.spr_top));
    c_trap = s.trap && ((s.tsel & s.thit) != 0);
    c_fp   = (s.fe0 || s.fe1) && ((s.flags & s.en) != 0);
    e.req  = !s.inh && (c_ill || c_priv || c_trap || c_fp);
    e.srr1 = 32'h0;
    if (e.req) begin
      if (c_ill)       e.srr1 = 32'h0000_1000;
      else if (c_priv) e.srr1 = 32'h0000_2000;
      else if (c_trap) e.srr1 = 32'h0000_4000;
      else             e.srr1 = 32'h0000_0800;
    end
    e.vec = (s.ip ? 32'hFFF0_0000 : 32'h0) + 32'h700;
    e.stall = 0;
    if (!s.fe0 && !s.fe1 && ((s.flags & ~s.sticky & ~s.en) != 0)) e.stall = s.sum ? 2 : 1;
    e.tag = tag;
    return e;
  endfunction

  task automatic run(input stim_t s, input string tag);
    exp_t e;
    e = predict(s, tag);
    @(negedge clk);
    hi_inhibit = s.inh; msr_pr = s.pr; msr_ip = s.ip; msr_fe0 = s.fe0; msr_fe1 = s.fe1;
    dec_illegal = s.ill; dec_nop_opt = s.nop; dec_supv = s.supv; dec_spr_move = s.spr_mv;
    spr_invalid = s.spr_inv; spr_top = s.spr_top; trap_op = s.trap; fp_sum_upd = s.sum;
    trap_sel = s.tsel; trap_hit = s.thit; fp_flags = s.flags; fp_sticky = s.sticky; fp_en = s.en;
    retire_vld = 1;
    @(negedge clk);
    retire_vld = 0; hi_inhibit = 0;
    q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares outputs against queued expectations away from the edge.
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " req"}, {31'b0, exc_req}, {31'b0, e.req});
        chk({e.tag, " srr1"}, exc_srr1, e.srr1);
        if (e.req) chk({e.tag, " vector"}, exc_vector, e.vec);
        rem = e.stall;
        chk({e.tag, " R9 stall"}, {31'b0, comp_stall}, {31'b0, rem > 0});
        if (rem > 0) rem--;
      end else begin
        chk("R1 idle req", {31'b0, exc_req}, 32'h0);
        chk("R9 stall tail", {31'b0, comp_stall}, {31'b0, rem > 0});
        if (rem > 0) rem--;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 reset req", {31'b0, exc_req}, 32'h0);
    chk("R8 reset srr1", exc_srr1, 32'h0);
    chk("R9 reset stall", {31'b0, comp_stall}, 32'h0);
    mon_en = 1;

    s = blank(); run(s, "R1 no cause");
    s = blank(); s.ill = 1; run(s, "R3 R2 illegal base0");
    s = blank(); s.ill = 1; s.nop = 1; run(s, "R3 optional nop");
    s = blank(); s.supv = 1; s.pr = 1; s.ip = 1; run(s, "R4 R2 priv base hi");
    s = blank(); s.supv = 1; run(s, "R4 supervisor mode");
    s = blank(); s.spr_mv = 1; s.spr_inv = 1; s.spr_top = 1; s.pr = 1; run(s, "R5 spr top1");
    s = blank(); s.spr_mv = 1; s.spr_inv = 1; s.pr = 1; run(s, "R5 spr top0");
    s = blank(); s.spr_mv = 1; s.spr_inv = 1; s.spr_top = 1; run(s, "R5 spr sup");
    s = blank(); s.trap = 1; s.tsel = 5'b00100; s.thit = 5'b00100; run(s, "R6 trap hit");
    s = blank(); s.trap = 1; s.tsel = 5'b00011; s.thit = 5'b01100; run(s, "R6 trap miss");
    s = blank(); s.fe0 = 1; s.flags = 5'b00010; s.en = 5'b00010; run(s, "R7 fp fe0");
    s = blank(); s.fe1 = 1; s.ip = 1; s.flags = 5'b10000; s.en = 5'b10001; run(s, "R7 fp fe1");
    s = blank(); s.flags = 5'b00010; s.en = 5'b00010; run(s, "R7 fe off");
    s = blank(); s.fe0 = 1; s.flags = 5'b00010; run(s, "R7 disabled");
    s = blank(); s.flags = 5'b00001; run(s, "R9 stall one");
    s = blank(); s.flags = 5'b01000; s.sum = 1; run(s, "R9 stall two");
    s = blank(); s.flags = 5'b00100; s.sticky = 5'b00100; s.sum = 1; run(s, "R9 already sticky");
    s = blank(); s.ill = 1; s.supv = 1; s.pr = 1; s.trap = 1; s.tsel = 1; s.thit = 1;
      s.fe0 = 1; s.flags = 1; s.en = 1; run(s, "R8 all causes");
    s = blank(); s.supv = 1; s.pr = 1; s.trap = 1; s.tsel = 1; s.thit = 1;
      s.fe0 = 1; s.flags = 1; s.en = 1; run(s, "R8 priv over trap");
    s = blank(); s.trap = 1; s.tsel = 2; s.thit = 2; s.fe1 = 1; s.flags = 4; s.en = 4;
      run(s, "R8 trap over fp");
    s = blank(); s.inh = 1; s.ill = 1; run(s, "R1 inhibited");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule